// File: doc/BRIEF.md
# Flag-Setting 64-bit Integer ALU

This block is the integer execute unit of a simple 64-bit datapath. It takes two 64-bit operands, a 3-bit operation code, a 6-bit shift count and a flag-capture enable. From these it forms a 64-bit result combinationally. It supports addition, subtraction, bitwise AND, OR and exclusive-OR, and zero-filling shifts in both directions.

Four condition flags sit in a register: negative, zero, signed overflow and carry. They are loaded on a rising clock edge only when the capture enable is high and the operation is add, subtract or AND. Any other cycle leaves them as they were. Subtraction defines carry as "no unsigned borrow". A following branch stage can therefore resolve both signed and unsigned comparisons from one subtraction.

Exclusive-OR with an all-ones operand gives the bitwise complement. The decoder uses this for NOT, so the ALU has no separate NOT operation.

Top module: `flag_alu`

## Requirements
- R1: `op_sel` selects the operation: 0 add, 1 subtract, 2 AND, 3 OR, 4 exclusive-OR, 5 shift left, 6 shift right. Code 7 drives a result of zero. For add, `result` is `op_a + op_b` modulo 2^64.
- R2: For subtract, `result` is `op_a - op_b` modulo 2^64.
- R3: AND, OR and exclusive-OR act bit by bit on `op_a` and `op_b`. Exclusive-OR with an all-ones `op_b` returns the complement of `op_a`.
- R4: Shift left moves `op_a` up by `shamt` positions and fills the vacated low bits with zeros. `shamt` = 0 returns `op_a` unchanged and `op_b` is ignored.
- R5: Shift right moves `op_a` down by `shamt` positions and fills the vacated high bits with zeros, so with `shamt` > 0 bit 63 of the result is 0.
- R6: Flags load on a rising `clk` edge when `set_flags` is 1 and `op_sel` is add, subtract or AND. The new values appear at the outputs after that edge.
- R7: A loaded `flag_n` equals bit 63 of the result. A loaded `flag_z` is 1 exactly when the result is all zeros.
- R8: For add, a loaded `flag_c` is the carry out of bit 63. A loaded `flag_v` is 1 when both operands share a sign bit that differs from the sign bit of the result.
- R9: For subtract, a loaded `flag_c` is 1 exactly when `op_a` >= `op_b` as unsigned numbers. A loaded `flag_v` is 1 on signed overflow of `op_a - op_b`.
- R10: For AND with `set_flags` = 1, `flag_c` and `flag_v` are loaded as 0.
- R11: When `set_flags` is 0, or the operation is OR, exclusive-OR, a shift or code 7, all four flags keep their values.
- R12: A synchronous active-high `rst` clears all four flags to 0 on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_a | input | 64 | First operand; the value that shifts act on |
| op_b | input | 64 | Second operand |
| op_sel | input | 3 | Operation code (see R1) |
| shamt | input | 6 | Shift count |
| set_flags | input | 1 | Flag-capture enable |
| result | output | 64 | Combinational result |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_v | output | 1 | Registered signed-overflow flag |
| flag_c | output | 1 | Registered carry / no-borrow flag |

## Verification
The bench targets the points where carry and overflow part ways:
- the all-ones plus one wrap, which must set carry and zero but not overflow;
- the most-positive plus one step, which must set overflow without carry;
- equal-operand and zero-minus-one subtractions.

A design that produced a borrow bit instead of a no-borrow bit would show carry inverted on every subtraction. An overflow taken from the raw `op_b` sign instead of the inverted one would go wrong on mixed-sign subtraction. The bench also issues OR, shifts and enable-low cycles right after carry and overflow have been set. A design that updated flags on those would visibly disturb them. Shift counts of 0 and 63 catch an off-by-one in the barrel stages or a fill with the wrong bit.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_ORR = 3'd3,
    ALU_XOR = 3'd4,
    ALU_SHL = 3'd5,
    ALU_SHR = 3'd6,
    ALU_NUL = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    sum   = wide[WIDTH-1:0];
    cout  = wide[WIDTH];
    ovf   = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int WIDTH = 64,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val,
  input  logic [SHW-1:0]   amt,
  input  logic             right,
  output logic [WIDTH-1:0] out
);
  logic [WIDTH-1:0] stage [SHW+1];

  assign stage[0] = val;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    always_comb begin
      if (!amt[s])
        stage[s+1] = stage[s];
      else if (right)
        stage[s+1] = stage[s] >> STEP;
      else
        stage[s+1] = stage[s] << STEP;
    end
  end

  assign out = stage[SHW];
endmodule

// File: rtl/alu_flagreg.sv
module alu_flagreg
  import flag_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       upd,
  input  alu_flags_t d,
  output alu_flags_t q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (upd)
      q <= d;
  end

  // R12: reset leaves the register cleared
  a_r12_reset_clear: assert property (@(posedge clk) rst |=> (q == '0));

  // R11: no capture request, no change
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(q));
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 64,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       op_sel,
  input  logic [SHW-1:0]   shamt,
  input  logic             set_flags,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c
);
  alu_op_e          op;
  logic [WIDTH-1:0] as_sum;
  logic             as_c;
  logic             as_v;
  logic [WIDTH-1:0] sh_out;
  logic             is_arith;
  logic             upd;
  alu_flags_t       nxt;
  alu_flags_t       cur;

  assign op = alu_op_e'(op_sel);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a    (op_a),
    .b    (op_b),
    .sub  (op == ALU_SUB),
    .sum  (as_sum),
    .cout (as_c),
    .ovf  (as_v)
  );

  alu_shift #(.WIDTH(WIDTH)) u_shift (
    .val   (op_a),
    .amt   (shamt),
    .right (op == ALU_SHR),
    .out   (sh_out)
  );

  always_comb begin
    unique case (op)
      ALU_ADD, ALU_SUB: result = as_sum;
      ALU_AND:          result = op_a & op_b;
      ALU_ORR:          result = op_a | op_b;
      ALU_XOR:          result = op_a ^ op_b;
      ALU_SHL, ALU_SHR: result = sh_out;
      default:          result = '0;
    endcase
  end

  always_comb begin
    is_arith = (op == ALU_ADD) || (op == ALU_SUB);
    upd      = set_flags && (is_arith || (op == ALU_AND));
    nxt.n    = result[WIDTH-1];
    nxt.z    = (result == '0);
    nxt.v    = is_arith ? as_v : 1'b0;
    nxt.c    = is_arith ? as_c : 1'b0;
  end

  alu_flagreg u_flags (
    .clk (clk),
    .rst (rst),
    .upd (upd),
    .d   (nxt),
    .q   (cur)
  );

  assign flag_n = cur.n;
  assign flag_z = cur.z;
  assign flag_v = cur.v;
  assign flag_c = cur.c;

  // R9: subtract carry means no unsigned borrow
  a_r9_sub_carry: assert property (@(posedge clk) disable iff (rst)
    (op == ALU_SUB) |-> (as_c == (op_a >= op_b)));

  // R8: add carry out iff the sum wrapped below an operand
  a_r8_add_carry: assert property (@(posedge clk) disable iff (rst)
    (op == ALU_ADD) |-> (as_c == (as_sum < op_a)));

  // R5: right shift by a nonzero count clears the top bit
  a_r5_shr_zero_fill: assert property (@(posedge clk) disable iff (rst)
    ((op == ALU_SHR) && (shamt != '0)) |-> !result[WIDTH-1]);

  // R7: captured negative flag follows the sign bit of the result
  a_r7_neg_capture: assert property (@(posedge clk) disable iff (rst)
    upd |=> (flag_n == $past(result[WIDTH-1])));

  // R10: AND never leaves carry or overflow set
  a_r10_and_clears: assert property (@(posedge clk) disable iff (rst)
    (upd && (op == ALU_AND)) |=> (!flag_c && !flag_v));
endmodule

// File: tb/flag_alu_bench.sv
`timescale 1ns/1ps
module flag_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [2:0]  op_sel = '0;
  logic [5:0]  shamt = '0;
  logic        set_flags = 1'b0;
  logic [63:0] result;
  logic        flag_n, flag_z, flag_v, flag_c;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [3:0] mflags = 4'b0000; // {n,z,v,c}

  always #2 clk = ~clk;

  flag_alu u_flag_alu (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .shamt(shamt), .set_flags(set_flags), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  function automatic logic [63:0] exp_res(logic [63:0] a, logic [63:0] b,
                                          logic [2:0] op, logic [5:0] sh);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a << sh;
      3'd6: return a >> sh;
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [3:0] exp_flags(logic [63:0] a, logic [63:0] b,
                                           logic [2:0] op, logic sf,
                                           logic [3:0] old);
    logic [63:0] r;
    logic v, c;
    r = exp_res(a, b, op, 6'd0);
    if (!sf || op > 3'd2) return old;
    if (op == 3'd0) begin
      c = (r < a);
      v = (a[63] == b[63]) && (r[63] != a[63]);
    end else if (op == 3'd1) begin
      c = (a >= b);
      v = (a[63] != b[63]) && (r[63] != a[63]);
    end else begin
      c = 1'b0;
      v = 1'b0;
    end
    return {r[63], (r == 64'd0), v, c};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string rtag(logic [2:0] op);
    case (op)
      3'd0: return "R1 add";
      3'd1: return "R2 sub";
      3'd2, 3'd3, 3'd4: return "R3 bitwise";
      3'd5: return "R4 shl";
      3'd6: return "R5 shr";
      default: return "R1 code7";
    endcase
  endfunction

  task automatic apply(logic [63:0] a, logic [63:0] b, logic [2:0] op,
                       logic [5:0] sh, logic sf);
    logic [63:0] er;
    logic [3:0]  fl;
    logic [3:0]  ef;
    string       ft;
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op; shamt = sh; set_flags = sf;
    #0.5;
    er = exp_res(a, b, op, sh);
    chk(result === er, rtag(op), result, er);
    ef = exp_flags(a, b, op, sf, mflags);
    if (!sf || op > 3'd2) ft = "R11 flags held";
    else if (op == 3'd2) ft = "R10/R7 AND flags";
    else if (op == 3'd1) ft = "R9/R7 sub flags";
    else ft = "R8/R7 add flags";
    mflags = ef;
    @(negedge clk);
    fl = {flag_n, flag_z, flag_v, flag_c};
    chk(fl === ef, ft, {60'd0, fl}, {60'd0, ef});
    set_flags = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({flag_n, flag_z, flag_v, flag_c} === 4'b0, "R12 reset",
        {60'd0, flag_n, flag_z, flag_v, flag_c}, 64'd0);
    rst = 1'b0;
    // R6/R8: all-ones + 1 sets Z and C, not V
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 3'd0, 6'd0, 1'b1);
    // R8: most positive + 1 sets V and N, not C
    apply(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 3'd0, 6'd0, 1'b1);
    // R11: OR, XOR, shifts and enable-low leave V/N intact
    apply(64'h0, 64'h0, 3'd3, 6'd0, 1'b1);
    apply(64'h0, 64'h0, 3'd4, 6'd0, 1'b1);
    apply(64'h0, 64'h0, 3'd5, 6'd3, 1'b1);
    apply(64'h0, 64'h0, 3'd7, 6'd0, 1'b1);
    apply(64'h0, 64'h0, 3'd0, 6'd0, 1'b0);
    // R9: equal operands: Z=1, C=1
    apply(64'd1234, 64'd1234, 3'd1, 6'd0, 1'b1);
    // R9: 0 - 1 borrows: C=0, N=1
    apply(64'd0, 64'd1, 3'd1, 6'd0, 1'b1);
    // R9: -1 vs +1 signed less, unsigned greater
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 3'd1, 6'd0, 1'b1);
    // R9: most negative - 1 overflows
    apply(64'h8000_0000_0000_0000, 64'd1, 3'd1, 6'd0, 1'b1);
    // R10: AND after V/C set clears them
    apply(64'hF000_0000_0000_0DC0, 64'hF000_0000_0000_3C00, 3'd2, 6'd0, 1'b1);
    // R3: XOR with all ones complements
    apply(64'h0000_0000_0000_0DC0, 64'hFFFF_FFFF_FFFF_FFFF, 3'd4, 6'd0, 1'b0);
    // R4/R5 shift corners
    apply(64'h8000_0000_0000_0001, 64'hDEAD, 3'd5, 6'd0, 1'b0);
    apply(64'h8000_0000_0000_0001, 64'h0, 3'd5, 6'd63, 1'b0);
    apply(64'h8000_0000_0000_0001, 64'h0, 3'd6, 6'd63, 1'b0);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 3'd6, 6'd1, 1'b0);
    apply(64'hA5A5_A5A5_A5A5_A5A5, 64'h0, 3'd6, 6'd0, 1'b0);
    // random mix
    void'($urandom(32'd1977));
    for (int i = 0; i < 400; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = (i % 5 == 0) ? ra : {$urandom, $urandom};
      apply(ra, rb, 3'($urandom % 8), 6'($urandom), 1'($urandom));
    end
    // R12: mid-run reset clears flags set just before
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 3'd0, 6'd0, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk({flag_n, flag_z, flag_v, flag_c} === 4'b0, "R12 mid reset",
        {60'd0, flag_n, flag_z, flag_v, flag_c}, 64'd0);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule